// File: doc/BRIEF.md
# CAN Node Fault Confinement Counters

This block keeps the two error counters of a CAN node, one for the transmit side and one for the receive side. From them it derives the node's fault state: active, warning, passive or bus-off. The protocol engine drives it with one-cycle strobes: a transmit error, an ordinary or severe receive error, a good transmission, a good reception, a receive overrun, and each time eleven recessive bits in a row are seen. From these strobes the block moves the counters and recovers the node from bus-off.

Six error flags follow the counter conditions and the overrun strobe. A flag is set whenever its condition holds and then stays set until software clears it. A clear has no effect while the condition is still present. Each flag has an enable bit, and a single interrupt line goes high when any enabled flag is set. A synchronous soft reset returns the whole block to its starting state.

Top module: `can_fault_confine`

## Requirements
- R1: Each `tx_err` strobe adds 8 to `tec`, and each `tx_ok` strobe subtracts 1, stopping at 0. When both arrive in the same cycle, only the error counts. `tec` is updated at the clock edge that samples the strobe.
- R2: `rx_err` adds 1 to `rec`, `rx_err_sev` adds 8 and `rx_ok` subtracts 1, stopping at 0. When several arrive together the priority is severe, then ordinary, then good.
- R3: An `rx_ok` strobe that arrives while `rec` is 128 or more loads `rec` with 119.
- R4: `rec` saturates at 511 and never wraps.
- R5: `node_state` is 3 (bus-off) when `tec` ≥ 256. Otherwise it is 2 (passive) when either counter is ≥ 128, then 1 (warning) when either counter is ≥ 96, and 0 (active) in all other cases.
- R6: While the node is bus-off, error strobes and success strobes leave both counters unchanged.
- R7: After 128 `rcsv_seq` strobes counted during bus-off, both counters become 0 and the state becomes active, at the edge that samples the 128th strobe. Strobes that arrive outside bus-off are not counted.
- R8: The bits of `err_flags` are: bit 0 overrun, bit 1 receive warning (96 ≤ `rec` < 128), bit 2 transmit warning (96 ≤ `tec` < 128), bit 3 receive passive (`rec` ≥ 128), bit 4 transmit passive (128 ≤ `tec` < 256), bit 5 bus-off (`tec` ≥ 256). A flag sets one edge after its condition holds on the counter outputs.
- R9: A flag bit is cleared by its `flag_clr` bit only when its condition is false at that edge. Otherwise the flag stays set. The overrun flag is set by an `rx_ovr` strobe.
- R10: `err_irq` is high exactly when some bit of `err_flags` is set and its `flag_en` bit is also set.
- R11: `srst` clears both counters, all flags and any recovery progress at the next edge, and it takes priority over every strobe.
- R12: While `rst_n` is low, the counters, the flags and the recovery progress are cleared at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| srst | input | 1 | Synchronous soft reset |
| tx_err | input | 1 | Transmit error strobe |
| tx_ok | input | 1 | Good transmission strobe |
| rx_err | input | 1 | Ordinary receive error strobe |
| rx_err_sev | input | 1 | Severe receive error strobe |
| rx_ok | input | 1 | Good reception strobe |
| rx_ovr | input | 1 | Receive overrun strobe |
| rcsv_seq | input | 1 | Eleven consecutive recessive bits seen |
| flag_en | input | 6 | Interrupt enable, one bit per flag |
| flag_clr | input | 6 | Write-to-clear, one bit per flag |
| tec | output | 9 | Transmit error counter |
| rec | output | 9 | Receive error counter |
| node_state | output | 2 | 0 active, 1 warning, 2 passive, 3 bus-off |
| err_flags | output | 6 | Error flags, bit order as in R8 |
| err_irq | output | 1 | Combined error interrupt |

## Verification
The assertions assume that every strobe is sampled on one edge only and that strobes arriving together are resolved by the priorities in R1 and R2, not forbidden. They also assume that `tec` stays below 256 outside bus-off, so adding 8 can never saturate there. The bench drives each strobe for exactly one cycle, changing it on the falling edge. It includes deliberate coincident patterns such as an error together with a success, and soft reset together with recovery progress. It sweeps the counters across every threshold and follows each step with a bench-side arithmetic model of the counters, the flags and the recovery count.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;

   typedef enum logic [1:0] {
      ST_ACTIVE  = 2'd0,
      ST_WARN    = 2'd1,
      ST_PASSIVE = 2'd2,
      ST_BUSOFF  = 2'd3
   } fc_state_e;

   localparam int FLAG_N  = 6;
   localparam int FI_OVR  = 0;
   localparam int FI_RXW  = 1;
   localparam int FI_TXW  = 2;
   localparam int FI_RXP  = 3;
   localparam int FI_TXP  = 4;
   localparam int FI_BOFF = 5;

endpackage

// File: rtl/can_fc_errcnt.sv
module can_fc_errcnt #(
   parameter int CNT_W       = 9,
   parameter int INC_MINOR   = 1,
   parameter int INC_MAJOR   = 8,
   parameter bit RELOAD_EN   = 1'b0,
   parameter int RELOAD_FROM = 128,
   parameter int RELOAD_VAL  = 119
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear,
   input  logic             freeze,
   input  logic             ev_minor,
   input  logic             ev_major,
   input  logic             ev_good,
   output logic [CNT_W-1:0] cnt
);

   localparam int EXT_W = CNT_W + 1;
   localparam int MAX_INT = (1 << CNT_W) - 1;
   localparam logic [EXT_W-1:0] MAX_EXT = EXT_W'(MAX_INT);

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("can_fc_errcnt: CNT_W out of range");
   end
   if (INC_MINOR < 1 || INC_MAJOR < INC_MINOR) begin : g_bad_step
      $error("can_fc_errcnt: increments must be positive and ordered");
   end
   if (RELOAD_EN && (RELOAD_VAL >= RELOAD_FROM || RELOAD_FROM > MAX_INT)) begin : g_bad_reload
      $error("can_fc_errcnt: reload value must lie below the reload threshold");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [EXT_W-1:0] major_sum;
   logic [EXT_W-1:0] minor_sum;
   logic [CNT_W-1:0] major_sat;
   logic [CNT_W-1:0] minor_sat;
   logic [CNT_W-1:0] good_val;
   logic             reload_hit;

   assign major_sum = {1'b0, cnt_q} + EXT_W'(INC_MAJOR);
   assign minor_sum = {1'b0, cnt_q} + EXT_W'(INC_MINOR);
   assign major_sat = (major_sum > MAX_EXT) ? MAX_EXT[CNT_W-1:0] : major_sum[CNT_W-1:0];
   assign minor_sat = (minor_sum > MAX_EXT) ? MAX_EXT[CNT_W-1:0] : minor_sum[CNT_W-1:0];

   if (RELOAD_EN) begin : g_reload
      assign reload_hit = (cnt_q >= CNT_W'(RELOAD_FROM));
   end else begin : g_plain
      assign reload_hit = 1'b0;
   end

   always_comb begin
      if (reload_hit) begin
         good_val = CNT_W'(RELOAD_VAL);
      end else if (cnt_q != '0) begin
         good_val = cnt_q - CNT_W'(1);
      end else begin
         good_val = cnt_q;
      end
   end

   always_comb begin
      cnt_d = cnt_q;
      if (clear) begin
         cnt_d = '0;
      end else if (!freeze) begin
         if (ev_major) begin
            cnt_d = major_sat;
         end else if (ev_minor) begin
            cnt_d = minor_sat;
         end else if (ev_good) begin
            cnt_d = good_val;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_d;
      end
   end

   assign cnt = cnt_q;

endmodule

// File: rtl/can_fc_recover.sv
module can_fc_recover #(
   parameter int SEQ_N = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic srst,
   input  logic in_busoff,
   input  logic seq_hit,
   output logic done
);

   localparam int RW = $clog2(SEQ_N + 1);
   localparam logic [RW-1:0] LAST = RW'(SEQ_N - 1);

   if (SEQ_N < 1) begin : g_bad_seq
      $error("can_fc_recover: SEQ_N must be at least 1");
   end

   logic [RW-1:0] seen_q;

   assign done = in_busoff & seq_hit & (seen_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
      end else if (srst || !in_busoff || done) begin
         seen_q <= '0;
      end else if (seq_hit) begin
         seen_q <= seen_q + RW'(1);
      end
   end

endmodule

// File: rtl/can_fc_flags.sv
module can_fc_flags #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         srst,
   input  logic [N-1:0] cond,
   input  logic [N-1:0] clr,
   input  logic [N-1:0] en,
   output logic [N-1:0] flags,
   output logic         irq
);

   if (N < 1) begin : g_bad_n
      $error("can_fc_flags: N must be at least 1");
   end

   logic [N-1:0] flag_q;
   logic [N-1:0] flag_d;

   for (genvar i = 0; i < N; i++) begin : g_flag
      assign flag_d[i] = !srst && (cond[i] || (flag_q[i] && !clr[i]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= '0;
      end else begin
         flag_q <= flag_d;
      end
   end

   assign flags = flag_q;
   assign irq   = |(flag_q & en);

endmodule

// File: rtl/can_fault_confine.sv
module can_fault_confine #(
   parameter int CNT_W       = 9,
   parameter int WARN_LIM    = 96,
   parameter int PASS_LIM    = 128,
   parameter int BOFF_LIM    = 256,
   parameter int TX_STEP     = 8,
   parameter int RX_SEV_STEP = 8,
   parameter int REC_RELOAD  = 119,
   parameter int RECOV_SEQ   = 128
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     srst,
   input  logic                     tx_err,
   input  logic                     tx_ok,
   input  logic                     rx_err,
   input  logic                     rx_err_sev,
   input  logic                     rx_ok,
   input  logic                     rx_ovr,
   input  logic                     rcsv_seq,
   input  logic [can_fc_pkg::FLAG_N-1:0] flag_en,
   input  logic [can_fc_pkg::FLAG_N-1:0] flag_clr,
   output logic [CNT_W-1:0]         tec,
   output logic [CNT_W-1:0]         rec,
   output logic [1:0]               node_state,
   output logic [can_fc_pkg::FLAG_N-1:0] err_flags,
   output logic                     err_irq
);

   import can_fc_pkg::*;

   localparam int MAX_INT = (1 << CNT_W) - 1;
   localparam logic [CNT_W-1:0] WARN_C = CNT_W'(WARN_LIM);
   localparam logic [CNT_W-1:0] PASS_C = CNT_W'(PASS_LIM);
   localparam logic [CNT_W-1:0] BOFF_C = CNT_W'(BOFF_LIM);

   if (!(WARN_LIM < PASS_LIM && PASS_LIM < BOFF_LIM && BOFF_LIM <= MAX_INT)) begin : g_bad_limits
      $error("can_fault_confine: thresholds must rise and fit the counter");
   end
   if (BOFF_LIM - 1 + TX_STEP > MAX_INT) begin : g_bad_headroom
      $error("can_fault_confine: counter too narrow for the bus-off step");
   end

   logic             busoff;
   logic             recov_done;
   logic             cnt_clear;
   logic [FLAG_N-1:0] flag_cond;
   fc_state_e        state_c;

   assign busoff    = (tec >= BOFF_C);
   assign cnt_clear = srst | recov_done;

   can_fc_errcnt #(
      .CNT_W     (CNT_W),
      .INC_MINOR (1),
      .INC_MAJOR (TX_STEP),
      .RELOAD_EN (1'b0)
   ) u_tec (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cnt_clear),
      .freeze   (busoff),
      .ev_minor (1'b0),
      .ev_major (tx_err),
      .ev_good  (tx_ok),
      .cnt      (tec)
   );

   can_fc_errcnt #(
      .CNT_W       (CNT_W),
      .INC_MINOR   (1),
      .INC_MAJOR   (RX_SEV_STEP),
      .RELOAD_EN   (1'b1),
      .RELOAD_FROM (PASS_LIM),
      .RELOAD_VAL  (REC_RELOAD)
   ) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (cnt_clear),
      .freeze   (busoff),
      .ev_minor (rx_err),
      .ev_major (rx_err_sev),
      .ev_good  (rx_ok),
      .cnt      (rec)
   );

   can_fc_recover #(
      .SEQ_N (RECOV_SEQ)
   ) u_recover (
      .clk       (clk),
      .rst_n     (rst_n),
      .srst      (srst),
      .in_busoff (busoff),
      .seq_hit   (rcsv_seq),
      .done      (recov_done)
   );

   always_comb begin
      flag_cond          = '0;
      flag_cond[FI_OVR]  = rx_ovr;
      flag_cond[FI_RXW]  = (rec >= WARN_C) && (rec < PASS_C);
      flag_cond[FI_TXW]  = (tec >= WARN_C) && (tec < PASS_C);
      flag_cond[FI_RXP]  = (rec >= PASS_C);
      flag_cond[FI_TXP]  = (tec >= PASS_C) && !busoff;
      flag_cond[FI_BOFF] = busoff;
   end

   can_fc_flags #(
      .N (FLAG_N)
   ) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .srst  (srst),
      .cond  (flag_cond),
      .clr   (flag_clr),
      .en    (flag_en),
      .flags (err_flags),
      .irq   (err_irq)
   );

   always_comb begin
      if (busoff) begin
         state_c = ST_BUSOFF;
      end else if (tec >= PASS_C || rec >= PASS_C) begin
         state_c = ST_PASSIVE;
      end else if (tec >= WARN_C || rec >= WARN_C) begin
         state_c = ST_WARN;
      end else begin
         state_c = ST_ACTIVE;
      end
   end

   assign node_state = state_c;

endmodule

// File: rtl/can_fc_checker.sv
module can_fc_checker #(
   parameter int CNT_W      = 9,
   parameter int BOFF_LIM   = 256,
   parameter int PASS_LIM   = 128,
   parameter int TX_STEP    = 8,
   parameter int REC_RELOAD = 119
) (
   input logic             clk,
   input logic             rst_n,
   input logic             srst,
   input logic             tx_err,
   input logic             rx_err,
   input logic             rx_err_sev,
   input logic             rx_ok,
   input logic             rcsv_seq,
   input logic [CNT_W-1:0] tec,
   input logic [CNT_W-1:0] rec,
   input logic [1:0]       node_state,
   input logic [5:0]       err_flags
);

   import can_fc_pkg::*;

   // R1
   tec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_err && node_state != ST_BUSOFF && !srst) |=> (tec == $past(tec) + CNT_W'(TX_STEP)));

   // R3
   rec_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_ok && !rx_err && !rx_err_sev && rec >= CNT_W'(PASS_LIM) && node_state != ST_BUSOFF && !srst)
      |=> (rec == CNT_W'(REC_RELOAD)));

   // R5
   busoff_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tec >= CNT_W'(BOFF_LIM)) |-> (node_state == ST_BUSOFF));

   // R6
   busoff_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (node_state == ST_BUSOFF && !rcsv_seq && !srst) |=> ($stable(tec) && $stable(rec)));

   // R7
   recover_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(node_state) == ST_BUSOFF && node_state != ST_BUSOFF) |-> (tec == '0 && rec == '0));

   // R8
   busoff_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tec >= CNT_W'(BOFF_LIM) && !srst) |=> err_flags[FI_BOFF]);

   // R11
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (tec == '0 && rec == '0 && err_flags == '0));

endmodule

bind can_fault_confine can_fc_checker #(
   .CNT_W      (CNT_W),
   .BOFF_LIM   (BOFF_LIM),
   .PASS_LIM   (PASS_LIM),
   .TX_STEP    (TX_STEP),
   .REC_RELOAD (REC_RELOAD)
) u_fc_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .srst       (srst),
   .tx_err     (tx_err),
   .rx_err     (rx_err),
   .rx_err_sev (rx_err_sev),
   .rx_ok      (rx_ok),
   .rcsv_seq   (rcsv_seq),
   .tec        (tec),
   .rec        (rec),
   .node_state (node_state),
   .err_flags  (err_flags)
);

// File: tb/tb_can_fault_confine.sv
module tb_can_fault_confine;

   localparam int EV_TXE  = 0;
   localparam int EV_TXOK = 1;
   localparam int EV_RXE  = 2;
   localparam int EV_SEV  = 3;
   localparam int EV_RXOK = 4;
   localparam int EV_OVR  = 5;
   localparam int EV_RCSV = 6;
   localparam int EV_SRST = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       srst = 1'b0;
   logic       tx_err = 1'b0, tx_ok = 1'b0, rx_err = 1'b0, rx_err_sev = 1'b0;
   logic       rx_ok = 1'b0, rx_ovr = 1'b0, rcsv_seq = 1'b0;
   logic [5:0] flag_en = 6'h3F;
   logic [5:0] flag_clr = 6'h00;
   logic [8:0] tec, rec;
   logic [1:0] node_state;
   logic [5:0] err_flags;
   logic       err_irq;

   int         n_run = 0;
   int         n_fail = 0;
   bit         finished = 1'b0;

   int         m_tec = 0, m_rec = 0, m_rcv = 0;
   logic [5:0] m_flags = 6'h00;

   always #10 clk = ~clk;

   can_fault_confine dut (
      .clk(clk), .rst_n(rst_n), .srst(srst),
      .tx_err(tx_err), .tx_ok(tx_ok), .rx_err(rx_err), .rx_err_sev(rx_err_sev),
      .rx_ok(rx_ok), .rx_ovr(rx_ovr), .rcsv_seq(rcsv_seq),
      .flag_en(flag_en), .flag_clr(flag_clr),
      .tec(tec), .rec(rec), .node_state(node_state),
      .err_flags(err_flags), .err_irq(err_irq)
   );

   function automatic logic [1:0] exp_state();
      if (m_tec >= 256) return 2'd3;
      if (m_tec >= 128 || m_rec >= 128) return 2'd2;
      if (m_tec >= 96 || m_rec >= 96) return 2'd1;
      return 2'd0;
   endfunction

   task automatic compare(input string tag);
      logic exp_irq;
      exp_irq = |(m_flags & flag_en);
      n_run++;
      if (tec !== 9'(m_tec) || rec !== 9'(m_rec) || node_state !== exp_state() ||
          err_flags !== m_flags || err_irq !== exp_irq) begin
         n_fail++;
         $display("FAIL %s: tec=%0d rec=%0d st=%0d flags=%b irq=%b, expected tec=%0d rec=%0d st=%0d flags=%b irq=%b",
                  tag, tec, rec, node_state, err_flags, err_irq,
                  m_tec, m_rec, exp_state(), m_flags, exp_irq);
      end
   endtask

   task automatic model(input logic [7:0] ev, input logic [5:0] clr);
      logic [5:0] cond;
      cond[0] = ev[EV_OVR];
      cond[1] = (m_rec >= 96 && m_rec < 128);
      cond[2] = (m_tec >= 96 && m_tec < 128);
      cond[3] = (m_rec >= 128);
      cond[4] = (m_tec >= 128 && m_tec < 256);
      cond[5] = (m_tec >= 256);
      m_flags = ev[EV_SRST] ? 6'h00 : (cond | (m_flags & ~clr));
      if (ev[EV_SRST]) begin
         m_tec = 0; m_rec = 0; m_rcv = 0;
      end else if (m_tec >= 256) begin
         if (ev[EV_RCSV]) begin
            if (m_rcv == 127) begin
               m_tec = 0; m_rec = 0; m_rcv = 0;
            end else begin
               m_rcv++;
            end
         end
      end else begin
         m_rcv = 0;
         if (ev[EV_TXE]) m_tec = m_tec + 8;
         else if (ev[EV_TXOK] && m_tec > 0) m_tec = m_tec - 1;
         if (ev[EV_SEV]) m_rec = (m_rec + 8 > 511) ? 511 : m_rec + 8;
         else if (ev[EV_RXE]) m_rec = (m_rec + 1 > 511) ? 511 : m_rec + 1;
         else if (ev[EV_RXOK]) m_rec = (m_rec >= 128) ? 119 : ((m_rec > 0) ? m_rec - 1 : 0);
      end
   endtask

   // Called at a falling edge; drives for one cycle and checks at the next falling edge.
   task automatic step(input logic [7:0] ev, input logic [5:0] clr, input string tag);
      tx_err = ev[EV_TXE]; tx_ok = ev[EV_TXOK]; rx_err = ev[EV_RXE];
      rx_err_sev = ev[EV_SEV]; rx_ok = ev[EV_RXOK]; rx_ovr = ev[EV_OVR];
      rcsv_seq = ev[EV_RCSV]; srst = ev[EV_SRST]; flag_clr = clr;
      @(posedge clk);
      model(ev, clr);
      @(negedge clk);
      tx_err = 1'b0; tx_ok = 1'b0; rx_err = 1'b0; rx_err_sev = 1'b0;
      rx_ok = 1'b0; rx_ovr = 1'b0; rcsv_seq = 1'b0; srst = 1'b0; flag_clr = 6'h00;
      compare(tag);
   endtask

   function automatic logic [7:0] bit8(input int idx);
      return 8'(1 << idx);
   endfunction

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=expired expected=completed");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      compare("R12");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R12");

      // R1 floor at zero
      step(bit8(EV_TXOK), 6'h00, "R1");
      // R5 sweep through warning and passive towards bus-off
      for (int i = 0; i < 31; i++) step(bit8(EV_TXE), 6'h00, "R5");
      for (int i = 0; i < 3; i++) step(bit8(EV_TXOK), 6'h00, "R1");
      step(bit8(EV_TXE) | bit8(EV_TXOK), 6'h00, "R1");
      step(bit8(EV_TXE), 6'h00, "R5");
      // R6 strobes during bus-off
      step(bit8(EV_RXE), 6'h00, "R6");
      step(bit8(EV_SEV), 6'h00, "R6");
      step(bit8(EV_RXOK), 6'h00, "R6");
      step(bit8(EV_TXE), 6'h00, "R6");
      step(bit8(EV_TXOK), 6'h00, "R6");
      // R7 recovery
      for (int i = 0; i < 127; i++) step(bit8(EV_RCSV), 6'h00, "R7");
      step(bit8(EV_RCSV), 6'h00, "R7");
      step(8'h00, 6'h00, "R8");
      step(8'h00, 6'h3F, "R9");

      // R11 soft reset drops recovery progress
      for (int i = 0; i < 32; i++) step(bit8(EV_TXE), 6'h00, "R11");
      for (int i = 0; i < 100; i++) step(bit8(EV_RCSV), 6'h00, "R11");
      step(bit8(EV_SRST) | bit8(EV_TXE) | bit8(EV_OVR), 6'h00, "R11");
      for (int i = 0; i < 5; i++) step(bit8(EV_RCSV), 6'h00, "R7");
      for (int i = 0; i < 32; i++) step(bit8(EV_TXE), 6'h00, "R7");
      for (int i = 0; i < 127; i++) step(bit8(EV_RCSV), 6'h00, "R11");
      step(bit8(EV_RCSV), 6'h00, "R7");
      step(8'h00, 6'h3F, "R9");

      // R2 receive counter sweep
      for (int i = 0; i < 100; i++) step(bit8(EV_RXE), 6'h00, "R2");
      for (int i = 0; i < 4; i++) step(bit8(EV_SEV), 6'h00, "R2");
      step(bit8(EV_RXOK), 6'h00, "R3");
      step(bit8(EV_RXOK), 6'h00, "R2");
      step(bit8(EV_RXE) | bit8(EV_SEV) | bit8(EV_RXOK), 6'h00, "R2");
      step(bit8(EV_RXE) | bit8(EV_RXOK), 6'h00, "R2");
      // R4 saturation
      for (int i = 0; i < 60; i++) step(bit8(EV_SEV), 6'h00, "R4");
      step(bit8(EV_RXE), 6'h00, "R4");
      step(bit8(EV_RXOK), 6'h00, "R3");
      for (int i = 0; i < 122; i++) step(bit8(EV_RXOK), 6'h00, "R2");
      step(8'h00, 6'h3F, "R9");

      // R9 clear ignored while condition holds, overrun set and clear
      for (int i = 0; i < 100; i++) step(bit8(EV_RXE), 6'h00, "R9");
      step(8'h00, 6'h3F, "R9");
      for (int i = 0; i < 10; i++) step(bit8(EV_RXOK), 6'h00, "R9");
      step(8'h00, 6'h00, "R9");
      step(8'h00, 6'h3F, "R9");
      step(bit8(EV_OVR), 6'h00, "R9");
      step(8'h00, 6'h00, "R9");
      step(bit8(EV_OVR), 6'h01, "R9");
      step(8'h00, 6'h01, "R9");

      // R10 interrupt masking
      step(bit8(EV_OVR), 6'h00, "R10");
      flag_en = 6'b111110;
      step(8'h00, 6'h00, "R10");
      flag_en = 6'b000001;
      step(8'h00, 6'h00, "R10");
      flag_en = 6'b000010;
      for (int i = 0; i < 10; i++) step(bit8(EV_RXE), 6'h00, "R10");
      flag_en = 6'h3F;

      // R12 asynchronous reset mid-run
      for (int i = 0; i < 20; i++) step(bit8(EV_TXE), 6'h00, "R12");
      rst_n = 1'b0;
      #3;
      m_tec = 0; m_rec = 0; m_rcv = 0; m_flags = 6'h00;
      compare("R12");
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      compare("R12");

      summary();
   end

endmodule